// File: doc/BRIEF.md
# Asynchronous Static RAM Write Sequencer

This block is a clocked controller that turns one local write request into a complete write cycle on an asynchronous static RAM port. That port has two address spaces: the storage array and a separate semaphore space. A request carries an address, data, byte enables, a space select and a flag that tells the sequencer whether the memory's output enable pin is held low during the write. The sequencer latches the request and shows the address with every strobe inactive. It then lowers read/write and the chosen enable together for a counted write pulse, turns its data drivers on and off at the right moments, and waits out write recovery. When the cycle is over it pulses `done`.

All timing is given in clock cycles through parameters: address setup, minimum write pulse, memory driver turn-off, data setup, data hold and write recovery. When output enable is low the memory may still be driving the bus as the pulse starts. In that case the sequencer holds its own drivers off for the turn-off interval and lengthens the pulse so that the full data setup time still fits before the strobe rises.

Top module: `sram_wr_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `mem_ce_n`, `mem_sem_n` and `mem_rw_n` are 1, `mem_be_n` is all ones, `mem_dq_oe` is 0 and `done` is 0.
- R2: `req_ack` is 1 in a cycle exactly when `req_valid` is 1, no write is in progress and `done` is 0. A request seen while `req_ack` is 0 is ignored: it neither changes `mem_addr` nor alters the write in progress.
- R3: After a request is accepted, `mem_addr` shows the request address from the next cycle on, and every strobe stays inactive for exactly `T_AS` cycles before the write pulse starts.
- R4: `mem_rw_n` and the selected enable fall in the same cycle and rise in the same cycle, so the enable is never asserted before read/write.
- R5: With `req_sem` = 0 (array) the pulse drives `mem_ce_n` = 0 and `mem_sem_n` = 1. With `req_sem` = 1 (semaphore) it drives `mem_ce_n` = 1 and `mem_sem_n` = 0. Outside the pulse both are 1.
- R6: The write pulse (`mem_rw_n` low) lasts max(`T_WP`, `T_DW`) cycles when `req_oe_low` = 0 and max(`T_WP`, `T_WZ` + `T_DW`) cycles when `req_oe_low` = 1.
- R7: `mem_dq_oe` rises in the first pulse cycle when `req_oe_low` = 0, and `T_WZ` cycles after the pulse starts when `req_oe_low` = 1. It stays 1 for `T_DH` cycles after the pulse ends, and while it is 1, `mem_dq_out` equals the request data.
- R8: The data drivers are on for at least `T_DW` cycles before the strobes rise.
- R9: After the strobes rise, `done` goes to 1 after max(`T_WR`, `T_DH`) cycles and stays 1 for exactly one cycle.
- R10: `mem_addr` does not change while `mem_rw_n` is low or `mem_dq_oe` is 1.
- R11: During the pulse, bit i of `mem_be_n` is the inverse of bit i of `req_be` (1 in `req_be` = byte written). Outside the pulse `mem_be_n` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ack | output | 1 | Request accepted this cycle |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| req_be | input | BEW | Byte enables, 1 = write that byte |
| req_sem | input | 1 | 0 = storage array, 1 = semaphore space |
| req_oe_low | input | 1 | Memory output enable is held low during the write |
| done | output | 1 | One-cycle pulse at the end of the write cycle |
| mem_addr | output | AW | Memory address |
| mem_dq_out | output | DW | Data toward the memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_ce_n | output | 1 | Array chip enable, active low |
| mem_sem_n | output | 1 | Semaphore enable, active low |
| mem_rw_n | output | 1 | Read/write strobe, low = write |
| mem_be_n | output | BEW | Byte enables, active low |

## Verification
Writes go to both spaces, each with output enable high and with output enable low. That separates a pulse sized for data setup alone from one that also covers driver turn-off, and it shows whether the enable encoding follows the space select. Both full and partial byte masks are used, with varied data, so a lane crossed in the byte enables or a wrong data word shows up. One test keeps a different request on the inputs during a whole write and through the `done` cycle. This shows that the address never moves under the strobe, and that the new request is taken only in the first cycle after `done`.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_PULSE = 2'd2,
    PH_POST  = 2'd3
  } wr_phase_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // cycles before own drivers may turn on inside the pulse
  function automatic int unsigned drive_delay(input int unsigned t_wz, input logic oe_low);
    return oe_low ? t_wz : 0;
  endfunction

  // strobe-low length: minimum pulse, or turnaround plus data setup
  function automatic int unsigned strobe_len(input int unsigned t_wp, input int unsigned t_wz,
                                             input int unsigned t_dw, input logic oe_low);
    return max2(t_wp, drive_delay(t_wz, oe_low) + t_dw);
  endfunction

  // cycles from strobe rise to end of cycle
  function automatic int unsigned post_len(input int unsigned t_wr, input int unsigned t_dh);
    return max2(t_wr, t_dh);
  endfunction

endpackage

// File: rtl/sram_wr_capture.sv
module sram_wr_capture #(
  parameter int AW  = 17,
  parameter int DW  = 36,
  parameter int BEW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [AW-1:0]  in_addr,
  input  logic [DW-1:0]  in_data,
  input  logic [BEW-1:0] in_be,
  input  logic           in_sem,
  input  logic           in_oe_low,
  output logic [AW-1:0]  q_addr,
  output logic [DW-1:0]  q_data,
  output logic [BEW-1:0] q_be,
  output logic           q_sem,
  output logic           q_oe_low
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_addr   <= '0;
      q_data   <= '0;
      q_be     <= '0;
      q_sem    <= 1'b0;
      q_oe_low <= 1'b0;
    end else if (load) begin
      q_addr   <= in_addr;
      q_data   <= in_data;
      q_be     <= in_be;
      q_sem    <= in_sem;
      q_oe_low <= in_oe_low;
    end
  end

endmodule

// File: rtl/sram_wr_phase.sv
module sram_wr_phase
  import sram_wr_pkg::*;
#(
  parameter int unsigned T_AS = 2,
  parameter int unsigned T_WP = 3,
  parameter int unsigned T_WZ = 2,
  parameter int unsigned T_DW = 2,
  parameter int unsigned T_DH = 1,
  parameter int unsigned T_WR = 2,
  parameter int          CW   = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      oe_low,
  output wr_phase_e phase,
  output logic      done,
  output logic      strobe_on,
  output logic      drive_on
);

  localparam logic [CW-1:0] AS_LAST  = CW'(T_AS - 1);
  localparam logic [CW-1:0] PL_HI    = CW'(strobe_len(T_WP, T_WZ, T_DW, 1'b0) - 1);
  localparam logic [CW-1:0] PL_LO    = CW'(strobe_len(T_WP, T_WZ, T_DW, 1'b1) - 1);
  localparam logic [CW-1:0] PO_LAST  = CW'(post_len(T_WR, T_DH) - 1);
  localparam logic [CW-1:0] WZ_LO    = CW'(drive_delay(T_WZ, 1'b1));
  localparam logic [CW-1:0] DH_LIMIT = CW'(T_DH);

  logic [CW-1:0] cnt;
  logic [CW-1:0] pulse_last;
  logic [CW-1:0] drive_at;

  // named phase-end events
  logic setup_end, pulse_end, post_end;

  assign pulse_last = oe_low ? PL_LO : PL_HI;
  assign drive_at   = oe_low ? WZ_LO : '0;
  assign setup_end  = (phase == PH_SETUP) && (cnt == AS_LAST);
  assign pulse_end  = (phase == PH_PULSE) && (cnt == pulse_last);
  assign post_end   = (phase == PH_POST)  && (cnt == PO_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_SETUP;
          cnt   <= '0;
        end
        PH_SETUP: if (setup_end) begin
          phase <= PH_PULSE;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        PH_PULSE: if (pulse_end) begin
          phase <= PH_POST;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        PH_POST: if (post_end) begin
          phase <= PH_IDLE;
          cnt   <= '0;
          done  <= 1'b1;
        end else cnt <= cnt + 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign strobe_on = (phase == PH_PULSE);
  assign drive_on  = ((phase == PH_PULSE) && (cnt >= drive_at)) ||
                     ((phase == PH_POST)  && (cnt <  DH_LIMIT));

  // R9: done is a single-cycle pulse
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3: a pulse is always preceded by the setup phase
  p_setup_before_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_on) |-> $past(phase) == PH_SETUP);
  // R7: with output enable low the drivers wait at the pulse start
  p_turnoff_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(strobe_on) && oe_low) |-> !drive_on);

endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins #(
  parameter int DW  = 36,
  parameter int BEW = 4
) (
  input  logic           strobe_on,
  input  logic           drive_on,
  input  logic           sem_sel,
  input  logic [BEW-1:0] be_q,
  input  logic [DW-1:0]  data_q,
  output logic           ce_n,
  output logic           sem_n,
  output logic           rw_n,
  output logic [BEW-1:0] be_n,
  output logic [DW-1:0]  dq_out,
  output logic           dq_oe
);

  // read/write and the selected enable share one source so neither leads
  assign rw_n  = !strobe_on;
  assign ce_n  = !(strobe_on && !sem_sel);
  assign sem_n = !(strobe_on &&  sem_sel);

  for (genvar i = 0; i < BEW; i++) begin : g_lane
    assign be_n[i] = !(strobe_on && be_q[i]);
  end

  assign dq_out = data_q;
  assign dq_oe  = drive_on;

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int          AW   = 17,
  parameter int          DW   = 36,
  parameter int          BEW  = 4,
  parameter int unsigned T_AS = 2,
  parameter int unsigned T_WP = 3,
  parameter int unsigned T_WZ = 2,
  parameter int unsigned T_DW = 2,
  parameter int unsigned T_DH = 1,
  parameter int unsigned T_WR = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ack,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_data,
  input  logic [BEW-1:0] req_be,
  input  logic           req_sem,
  input  logic           req_oe_low,
  output logic           done,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_dq_out,
  output logic           mem_dq_oe,
  output logic           mem_ce_n,
  output logic           mem_sem_n,
  output logic           mem_rw_n,
  output logic [BEW-1:0] mem_be_n
);

  localparam int unsigned MAXLEN = max2(max2(T_AS, strobe_len(T_WP, T_WZ, T_DW, 1'b1)),
                                        post_len(T_WR, T_DH));
  localparam int CW = $clog2(MAXLEN + 1) + 1;

  wr_phase_e      phase;
  logic           strobe_on, drive_on, accept;
  logic [DW-1:0]  data_q;
  logic [BEW-1:0] be_q;
  logic           sem_q, oe_low_q;

  assign accept  = req_valid && (phase == PH_IDLE) && !done;
  assign req_ack = accept;

  sram_wr_capture #(.AW(AW), .DW(DW), .BEW(BEW)) u_cap (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .in_addr(req_addr), .in_data(req_data), .in_be(req_be),
    .in_sem(req_sem), .in_oe_low(req_oe_low),
    .q_addr(mem_addr), .q_data(data_q), .q_be(be_q),
    .q_sem(sem_q), .q_oe_low(oe_low_q)
  );

  sram_wr_phase #(
    .T_AS(T_AS), .T_WP(T_WP), .T_WZ(T_WZ), .T_DW(T_DW),
    .T_DH(T_DH), .T_WR(T_WR), .CW(CW)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .start(accept), .oe_low(oe_low_q),
    .phase(phase), .done(done), .strobe_on(strobe_on), .drive_on(drive_on)
  );

  sram_wr_pins #(.DW(DW), .BEW(BEW)) u_pins (
    .strobe_on(strobe_on), .drive_on(drive_on), .sem_sel(sem_q),
    .be_q(be_q), .data_q(data_q),
    .ce_n(mem_ce_n), .sem_n(mem_sem_n), .rw_n(mem_rw_n),
    .be_n(mem_be_n), .dq_out(mem_dq_out), .dq_oe(mem_dq_oe)
  );

  // checker-only measurement of the strobe-low run
  logic [CW-1:0] low_run;
  always_ff @(posedge clk) begin
    if (!rst_n)         low_run <= '0;
    else if (!mem_rw_n) low_run <= low_run + 1'b1;
    else                low_run <= '0;
  end

  // R6: pulse length depends on the output-enable setting
  p_pulse_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rw_n) |-> low_run == CW'(strobe_len(T_WP, T_WZ, T_DW, oe_low_q)));
  // R5: exactly one enable is low during the pulse
  p_enable_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rw_n |-> (mem_ce_n != mem_sem_n));
  // R4: no enable is low without read/write low
  p_enable_not_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rw_n |-> (mem_ce_n && mem_sem_n));
  // R10: address is held while strobing or driving
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rw_n || mem_dq_oe) |=> ((mem_rw_n && !mem_dq_oe) || $stable(mem_addr)));
  // R11: byte enables are idle outside the pulse
  p_be_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rw_n |-> (&mem_be_n));
  // R2: acceptance is never repeated in the following cycle
  p_ack_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

endmodule

// File: tb/sram_wr_seq_tb.sv
module sram_wr_seq_tb;

  localparam int AW = 17, DW = 36, BEW = 4;
  localparam int T_AS = 2, T_WP = 3, T_WZ = 2, T_DW = 2, T_DH = 1, T_WR = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_sem = 1'b0, req_oe_low = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [BEW-1:0] req_be = '0;
  logic req_ack, done, mem_dq_oe, mem_ce_n, mem_sem_n, mem_rw_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out;
  logic [BEW-1:0] mem_be_n;

  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  sram_wr_seq #(.AW(AW), .DW(DW), .BEW(BEW), .T_AS(T_AS), .T_WP(T_WP), .T_WZ(T_WZ),
                .T_DW(T_DW), .T_DH(T_DH), .T_WR(T_WR)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ack(req_ack),
    .req_addr(req_addr), .req_data(req_data), .req_be(req_be), .req_sem(req_sem),
    .req_oe_low(req_oe_low), .done(done), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_ce_n(mem_ce_n), .mem_sem_n(mem_sem_n),
    .mem_rw_n(mem_rw_n), .mem_be_n(mem_be_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 64'd0, 64'd1);
    summary();
  end

  // drive a request at a negedge and check that it is taken at the next edge
  task automatic start_req(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic [BEW-1:0] be, input logic sem, input logic oel);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d; req_be = be;
    req_sem = sem; req_oe_low = oel;
    #1;
    chk(req_ack === 1'b1, "R2", "ack on idle request", 64'(req_ack), 64'd1);
    @(posedge clk);
  endtask

  // follow one write cycle from the accept edge; optionally keep a new request pending
  task automatic watch(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [BEW-1:0] be, input logic sem, input logic oel,
                       input bit keep, input logic [AW-1:0] alt_a);
    int wz, p, post, rise_k, done_k, fall_seen, rise_seen, drv_in_pulse;
    wz = oel ? T_WZ : 0;
    p = (T_WP > wz + T_DW) ? T_WP : wz + T_DW;
    post = (T_WR > T_DH) ? T_WR : T_DH;
    rise_k = T_AS + p;
    done_k = rise_k + post + 1;
    fall_seen = 0; rise_seen = 0; drv_in_pulse = 0;
    for (int k = 1; k <= done_k + 1; k++) begin
      bit in_p, exp_oe;
      @(negedge clk);
      in_p = (k > T_AS) && (k <= rise_k);
      exp_oe = ((k > T_AS + wz) && (k <= rise_k)) || ((k > rise_k) && (k <= rise_k + T_DH));
      if (!mem_rw_n && fall_seen == 0) fall_seen = k;
      if (fall_seen != 0 && mem_rw_n && rise_seen == 0) rise_seen = k - 1;
      if (in_p && mem_dq_oe) drv_in_pulse++;
      chk(mem_rw_n === !in_p, (k <= T_AS) ? "R3" : "R6", "rw_n", 64'(mem_rw_n), 64'(!in_p));
      chk(mem_ce_n === !(in_p && !sem), "R5", "ce_n", 64'(mem_ce_n), 64'(!(in_p && !sem)));
      chk(mem_sem_n === !(in_p && sem), "R5", "sem_n", 64'(mem_sem_n), 64'(!(in_p && sem)));
      chk((mem_ce_n && mem_sem_n) === mem_rw_n, "R4", "enable vs rw_n",
          64'(mem_ce_n && mem_sem_n), 64'(mem_rw_n));
      chk(mem_be_n === (in_p ? ~be : {BEW{1'b1}}), "R11", "be_n", 64'(mem_be_n),
          64'(in_p ? ~be : {BEW{1'b1}}));
      chk(mem_dq_oe === exp_oe, "R7", "dq_oe", 64'(mem_dq_oe), 64'(exp_oe));
      if (mem_dq_oe) chk(mem_dq_out === d, "R7", "dq_out", 64'(mem_dq_out), 64'(d));
      if (k <= done_k) chk(mem_addr === a, "R10", "mem_addr", 64'(mem_addr), 64'(a));
      chk(done === (k == done_k), "R9", "done", 64'(done), 64'(k == done_k));
      if (k <= done_k) chk(req_ack === 1'b0, "R2", "ack while busy", 64'(req_ack), 64'd0);
      else chk(req_ack === keep, "R2", "ack after done", 64'(req_ack), 64'(keep));
      if (k == 1) begin
        if (keep) begin
          req_addr = alt_a; req_data = ~d;
        end else req_valid = 1'b0;
      end
    end
    chk(fall_seen == T_AS + 1, "R3", "pulse start cycle", 64'(fall_seen), 64'(T_AS + 1));
    chk(rise_seen - fall_seen + 1 == p, "R6", "pulse width", 64'(rise_seen - fall_seen + 1), 64'(p));
    chk(drv_in_pulse >= T_DW, "R8", "data setup cycles", 64'(drv_in_pulse), 64'(T_DW));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(mem_rw_n === 1'b1 && mem_ce_n === 1'b1 && mem_sem_n === 1'b1, "R1", "strobes in reset",
        64'({mem_rw_n, mem_ce_n, mem_sem_n}), 64'h7);
    chk(mem_be_n === {BEW{1'b1}}, "R1", "be_n in reset", 64'(mem_be_n), 64'hf);
    chk(mem_dq_oe === 1'b0 && done === 1'b0, "R1", "oe/done in reset", 64'({mem_dq_oe, done}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_rw_n === 1'b1 && mem_dq_oe === 1'b0 && done === 1'b0, "R1", "after reset",
        64'({mem_rw_n, mem_dq_oe, done}), 64'h4);
  endtask

  task automatic t_array_oe_high();
    start_req(17'h0_1234, 36'h1_2345_6789, 4'b1111, 1'b0, 1'b0);
    watch(17'h0_1234, 36'h1_2345_6789, 4'b1111, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_array_oe_low();
    start_req(17'h1_0F0F, 36'hA_5A5A_5A5A, 4'b0101, 1'b0, 1'b1);
    watch(17'h1_0F0F, 36'hA_5A5A_5A5A, 4'b0101, 1'b0, 1'b1, 1'b0, '0);
  endtask

  task automatic t_sem_oe_low();
    start_req(17'h0_0007, 36'h0_0000_0001, 4'b0001, 1'b1, 1'b1);
    watch(17'h0_0007, 36'h0_0000_0001, 4'b0001, 1'b1, 1'b1, 1'b0, '0);
  endtask

  task automatic t_sem_oe_high();
    start_req(17'h0_0003, 36'hF_0000_000F, 4'b1010, 1'b1, 1'b0);
    watch(17'h0_0003, 36'hF_0000_000F, 4'b1010, 1'b1, 1'b0, 1'b0, '0);
  endtask

  // R2: a request held during a write is ignored until done has pulsed
  task automatic t_ignore_pending();
    start_req(17'h0_AAAA, 36'h3_3333_3333, 4'b1100, 1'b0, 1'b1);
    watch(17'h0_AAAA, 36'h3_3333_3333, 4'b1100, 1'b0, 1'b1, 1'b1, 17'h1_5555);
    @(posedge clk);
    watch(17'h1_5555, ~36'h3_3333_3333, 4'b1100, 1'b0, 1'b1, 1'b0, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_array_oe_high();
    t_array_oe_low();
    t_sem_oe_low();
    t_sem_oe_high();
    t_ignore_pending();
    repeat (3) @(negedge clk);
    summary();
  end

endmodule